// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver with Source Selector

This block takes stereo PCM audio from one of three serial input groups. Each group brings a data line, a frame clock and a bit clock. All three groups are synchronized into a faster system clock. A select input then picks the group that feeds a single deserializer.

The deserializer understands four framing conventions: frame-aligned (left-justified), one-bit-delayed (I2S), end-aligned (right-justified) and pulse-framed (DSP style). Each framing works with word lengths of 16, 20 or 24 bits. Every word is sign-extended to a 24-bit output. A left/right pair is presented together with a one-cycle strobe.

A change of the select or the format takes effect only at a frame start, and the partial frame is dropped. When the forwarding enable is high, the raw signals of the active group also appear on three pass-through outputs.

Top module: `audio_serial_rx`

## Requirements
- R1: The format input splits into two fields. Bits [1:0] choose the framing: 00 frame-aligned, 01 one-bit-delayed, 10 end-aligned, 11 pulse-framed. Bits [3:2] choose the word length: 00 = 16, 01 = 20, 10 or 11 = 24 bits.
- R2: Frame-aligned: the MSB is the first bit sampled after a frame-clock change, and a high frame clock carries the left word.
- R3: One-bit-delayed: the MSB is the second bit after a frame-clock change, and a low frame clock carries the left word.
- R4: End-aligned: the LSB of each word is the last bit sampled before the frame-clock change that closes its half, and a high frame clock carries the left word.
- R5: Pulse-framed: the left MSB is the bit sampled while a one-bit frame pulse is high, and the right word follows immediately after the last left bit.
- R6: Serial words are MSB first in two's complement. Words shorter than 24 bits are sign-extended on both outputs.
- R7: After the right word of a complete frame, the left and right samples are presented together with a valid pulse one system cycle long. The sample outputs change only in that cycle.
- R8: Select values 00, 01 and 10 choose groups 0, 1 and 2. Value 11 is reserved and keeps the group already active.
- R9: A new select or format value is applied at the next frame start of the active configuration. No sample is built from a frame that was cut by the change.
- R10: While the forwarding enable is high, the pass-through outputs carry the raw data, frame clock and bit clock of the active group. While it is low, all three are 0.
- R11: During and after reset, valid is 0, both samples are 0 and group 0 is active in frame-aligned 16-bit format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 3 | Serial data, one bit per input group |
| frm_clk_i | input | 3 | Frame clock, one bit per input group |
| bit_clk_i | input | 3 | Bit clock, one bit per input group |
| src_sel_i | input | 2 | Requested input group |
| fmt_i | input | 4 | Requested framing and word length |
| fwd_en_i | input | 1 | Enables the pass-through outputs |
| fwd_data_o | output | 1 | Forwarded data of the active group |
| fwd_frm_o | output | 1 | Forwarded frame clock of the active group |
| fwd_bit_o | output | 1 | Forwarded bit clock of the active group |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions rely on a few properties of the inputs:
- Each bit clock has high and low phases of at least two system cycles.
- Data and frame clock change only while the bit clock is low.
- Each half frame is at least one word long.

Under these conditions, two emissions can never land in adjacent cycles, and a switch can only follow a detected frame start. The stimulus respects all of them. It holds each bit-clock phase for four system cycles and changes data and frame clock only on the falling phase. It uses 32-bit half slots, or 64-bit pulse frames, around random words. Select and format changes are applied between frames or in the middle of a frame, never at an edge the bench relies on.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      FRM_LJ  = 2'd0,
      FRM_I2S = 2'd1,
      FRM_RJ  = 2'd2,
      FRM_DSP = 2'd3
   } frame_mode_e;

   typedef struct packed {
      logic [1:0]  wl_code;
      frame_mode_e mode;
   } fmt_t;

   // word length in bits for a length code; code 3 falls back to 24
   function automatic int wl_bits(logic [1:0] code);
      case (code)
         2'd0:    return 16;
         2'd1:    return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int NUM_SRC = 3,
   parameter int STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] data_i,
   input  logic [NUM_SRC-1:0] frm_i,
   input  logic [NUM_SRC-1:0] bclk_i,
   output logic [NUM_SRC-1:0] data_s,
   output logic [NUM_SRC-1:0] frm_s,
   output logic [NUM_SRC-1:0] tick
);

   if (STAGES < 2) begin : g_bad_stages
      $error("aud_rx_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_grp
      logic [STAGES-1:0] d_sh;
      logic [STAGES-1:0] f_sh;
      logic [STAGES-1:0] b_sh;
      logic              b_prev;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_sh   <= '0;
            f_sh   <= '0;
            b_sh   <= '0;
            b_prev <= 1'b0;
         end else begin
            d_sh   <= {d_sh[STAGES-2:0], data_i[g]};
            f_sh   <= {f_sh[STAGES-2:0], frm_i[g]};
            b_sh   <= {b_sh[STAGES-2:0], bclk_i[g]};
            b_prev <= b_sh[STAGES-1];
         end
      end

      assign data_s[g] = d_sh[STAGES-1];
      assign frm_s[g]  = f_sh[STAGES-1];
      assign tick[g]   = b_sh[STAGES-1] & ~b_prev;
   end

endmodule

// File: rtl/aud_rx_srcsel.sv
module aud_rx_srcsel
   import aud_rx_pkg::*;
#(
   parameter int NUM_SRC = 3,
   parameter int SEL_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEL_W-1:0]   src_sel_i,
   input  fmt_t               fmt_i,
   input  logic               frame_start_i,
   input  logic [NUM_SRC-1:0] data_s,
   input  logic [NUM_SRC-1:0] frm_s,
   input  logic [NUM_SRC-1:0] tick,
   input  logic [NUM_SRC-1:0] data_raw,
   input  logic [NUM_SRC-1:0] frm_raw,
   input  logic [NUM_SRC-1:0] bclk_raw,
   input  logic               fwd_en_i,
   output logic [SEL_W-1:0]   act_sel,
   output fmt_t               act_fmt,
   output logic               flush_o,
   output logic               act_data,
   output logic               act_frm,
   output logic               act_tick,
   output logic               fwd_data_o,
   output logic               fwd_frm_o,
   output logic               fwd_bit_o
);

   logic [SEL_W-1:0] sel_eff;
   logic             pending;

   // a reserved select value keeps the active group
   assign sel_eff = (int'(src_sel_i) < NUM_SRC) ? src_sel_i : act_sel;
   assign pending = (sel_eff != act_sel) || (fmt_i != act_fmt);
   assign flush_o = pending & frame_start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sel <= '0;
         act_fmt <= '0;
      end else if (flush_o) begin
         act_sel <= sel_eff;
         act_fmt <= fmt_i;
      end
   end

   assign act_data = data_s[act_sel];
   assign act_frm  = frm_s[act_sel];
   assign act_tick = tick[act_sel];

   assign fwd_data_o = fwd_en_i & data_raw[act_sel];
   assign fwd_frm_o  = fwd_en_i & frm_raw[act_sel];
   assign fwd_bit_o  = fwd_en_i & bclk_raw[act_sel];

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
   import aud_rx_pkg::*;
#(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              sdata_i,
   input  logic              sfrm_i,
   input  fmt_t              fmt_i,
   input  logic              flush_i,
   output logic              frame_start_o,
   output logic [DATA_W-1:0] left_o,
   output logic [DATA_W-1:0] right_o,
   output logic              valid_o
);

   localparam int POS_W = $clog2(2 * DATA_W + 1);

   logic              frm_prev_q, first_q, chan_q, armed_q, have_left_q;
   logic [POS_W-1:0]  pos_q;
   logic [DATA_W-1:0] sr_q, left_hold_q;

   logic [POS_W-1:0]  wl, wl_m1, wl2_m1, pos_now;
   logic              edge_any, edge_rise, edge_fall, restart;
   logic              chan_now, armed_now, cap, is_left;
   logic [DATA_W-1:0] sr_next, word, word_ext;

   function automatic logic [DATA_W-1:0] extend(logic [DATA_W-1:0] w, int n);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) begin
         r[i] = (i < n) ? w[i] : w[n-1];
      end
      return r;
   endfunction

   assign wl     = POS_W'(wl_bits(fmt_i.wl_code));
   assign wl_m1  = wl - POS_W'(1);
   assign wl2_m1 = (wl << 1) - POS_W'(1);

   assign edge_any  = tick_i & ~first_q & (sfrm_i ^ frm_prev_q);
   assign edge_rise = edge_any & sfrm_i;
   assign edge_fall = edge_any & ~sfrm_i;

   assign frame_start_o = (fmt_i.mode == FRM_I2S) ? edge_fall : edge_rise;
   assign restart       = (fmt_i.mode == FRM_DSP) ? edge_rise : edge_any;
   assign pos_now       = restart ? '0 : pos_q;
   assign chan_now      = edge_any ? ((fmt_i.mode == FRM_I2S) ? ~sfrm_i : sfrm_i) : chan_q;
   assign sr_next       = {sr_q[DATA_W-2:0], sdata_i};
   assign armed_now     = armed_q | frame_start_o;

   always_comb begin
      cap     = 1'b0;
      word    = sr_next;
      is_left = chan_now;
      unique case (fmt_i.mode)
         FRM_LJ:  cap = tick_i & (pos_now == wl_m1);
         FRM_I2S: cap = tick_i & (pos_now == wl);
         FRM_RJ: begin
            cap     = edge_any;
            word    = sr_q;
            is_left = frm_prev_q;
         end
         FRM_DSP: begin
            cap     = tick_i & ((pos_now == wl_m1) | (pos_now == wl2_m1));
            is_left = (pos_now == wl_m1);
         end
      endcase
   end

   assign word_ext = extend(word, wl_bits(fmt_i.wl_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_prev_q  <= 1'b0;
         first_q     <= 1'b1;
         chan_q      <= 1'b0;
         armed_q     <= 1'b0;
         have_left_q <= 1'b0;
         pos_q       <= '1;
         sr_q        <= '0;
         left_hold_q <= '0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (tick_i) begin
            frm_prev_q <= sfrm_i;
            first_q    <= 1'b0;
            sr_q       <= sr_next;
            pos_q      <= (&pos_now) ? pos_now : pos_now + POS_W'(1);
            chan_q     <= chan_now;
            armed_q    <= armed_now;
         end
         if (cap && armed_now) begin
            if (is_left) begin
               left_hold_q <= word_ext;
               have_left_q <= 1'b1;
            end else if (have_left_q) begin
               left_o      <= left_hold_q;
               right_o     <= word_ext;
               valid_o     <= 1'b1;
               have_left_q <= 1'b0;
            end
         end
         if (flush_i) begin
            first_q     <= 1'b1;
            armed_q     <= 1'b0;
            have_left_q <= 1'b0;
            pos_q       <= '1;
         end
      end
   end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int NUM_SRC     = 3,
   parameter int SEL_W       = 2,
   parameter int DATA_W      = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] ser_data_i,
   input  logic [NUM_SRC-1:0] frm_clk_i,
   input  logic [NUM_SRC-1:0] bit_clk_i,
   input  logic [SEL_W-1:0]   src_sel_i,
   input  logic [3:0]         fmt_i,
   input  logic               fwd_en_i,
   output logic               fwd_data_o,
   output logic               fwd_frm_o,
   output logic               fwd_bit_o,
   output logic [DATA_W-1:0]  left_o,
   output logic [DATA_W-1:0]  right_o,
   output logic               valid_o
);

   if (NUM_SRC < 2 || NUM_SRC > (1 << SEL_W)) begin : g_bad_src
      $error("audio_serial_rx: NUM_SRC does not fit SEL_W");
   end
   if (DATA_W < 24) begin : g_bad_width
      $error("audio_serial_rx: DATA_W must hold a 24-bit word");
   end

   logic [NUM_SRC-1:0] data_s, frm_s, tick;
   logic [SEL_W-1:0]   act_sel;
   fmt_t               act_fmt;
   logic               flush, act_data, act_frm, act_tick, frame_start;

   aud_rx_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_i (ser_data_i),
      .frm_i  (frm_clk_i),
      .bclk_i (bit_clk_i),
      .data_s (data_s),
      .frm_s  (frm_s),
      .tick   (tick)
   );

   aud_rx_srcsel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .clk           (clk),
      .rst_n         (rst_n),
      .src_sel_i     (src_sel_i),
      .fmt_i         (fmt_t'(fmt_i)),
      .frame_start_i (frame_start),
      .data_s        (data_s),
      .frm_s         (frm_s),
      .tick          (tick),
      .data_raw      (ser_data_i),
      .frm_raw       (frm_clk_i),
      .bclk_raw      (bit_clk_i),
      .fwd_en_i      (fwd_en_i),
      .act_sel       (act_sel),
      .act_fmt       (act_fmt),
      .flush_o       (flush),
      .act_data      (act_data),
      .act_frm       (act_frm),
      .act_tick      (act_tick),
      .fwd_data_o    (fwd_data_o),
      .fwd_frm_o     (fwd_frm_o),
      .fwd_bit_o     (fwd_bit_o)
   );

   aud_rx_deser #(.DATA_W(DATA_W)) u_deser (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (act_tick),
      .sdata_i       (act_data),
      .sfrm_i        (act_frm),
      .fmt_i         (act_fmt),
      .flush_i       (flush),
      .frame_start_o (frame_start),
      .left_o        (left_o),
      .right_o       (right_o),
      .valid_o       (valid_o)
   );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
   parameter int NUM_SRC = 3,
   parameter int SEL_W   = 2,
   parameter int DATA_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_o,
   input logic [DATA_W-1:0] left_o,
   input logic [DATA_W-1:0] right_o,
   input logic              fwd_en_i,
   input logic              fwd_data_o,
   input logic              fwd_frm_o,
   input logic              fwd_bit_o,
   input logic [SEL_W-1:0]  act_sel,
   input logic [3:0]        act_fmt,
   input logic              frame_start
);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R7
   sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((left_o != $past(left_o)) || (right_o != $past(right_o))) |-> valid_o);

   // R8
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(act_sel) < NUM_SRC);

   // R9
   switch_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_sel != $past(act_sel)) || (act_fmt != $past(act_fmt))) |-> $past(frame_start));

   // R10
   fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_en_i |-> (!fwd_data_o && !fwd_frm_o && !fwd_bit_o));

   // R6
   sext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ($past(act_fmt[3:2]) == 2'd0)) |->
      ((&left_o[DATA_W-1:15] || !(|left_o[DATA_W-1:15])) &&
       (&right_o[DATA_W-1:15] || !(|right_o[DATA_W-1:15]))));

   // R6
   sext20_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ($past(act_fmt[3:2]) == 2'd1)) |->
      ((&left_o[DATA_W-1:19] || !(|left_o[DATA_W-1:19])) &&
       (&right_o[DATA_W-1:19] || !(|right_o[DATA_W-1:19]))));

endmodule

bind audio_serial_rx aud_rx_chk #(
   .NUM_SRC (NUM_SRC),
   .SEL_W   (SEL_W),
   .DATA_W  (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .valid_o     (valid_o),
   .left_o      (left_o),
   .right_o     (right_o),
   .fwd_en_i    (fwd_en_i),
   .fwd_data_o  (fwd_data_o),
   .fwd_frm_o   (fwd_frm_o),
   .fwd_bit_o   (fwd_bit_o),
   .act_sel     (act_sel),
   .act_fmt     (act_fmt),
   .frame_start (frame_start)
);

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;

   localparam int CLK_P    = 10;
   localparam int HALF_BIT = 4;
   localparam int SLOT     = 32;
   localparam int NSRC     = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  sdat = '0, sfrm = '0, sbck = '0;
   logic [1:0]  sel = '0;
   logic [3:0]  fmt = '0;
   logic        fwd_en = 1'b0;
   logic        fwd_data, fwd_frm, fwd_bit, valid_o;
   logic [23:0] left_o, right_o;

   always #(CLK_P / 2) clk = ~clk;

   audio_serial_rx uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_data_i (sdat),
      .frm_clk_i  (sfrm),
      .bit_clk_i  (sbck),
      .src_sel_i  (sel),
      .fmt_i      (fmt),
      .fwd_en_i   (fwd_en),
      .fwd_data_o (fwd_data),
      .fwd_frm_o  (fwd_frm),
      .fwd_bit_o  (fwd_bit),
      .left_o     (left_o),
      .right_o    (right_o),
      .valid_o    (valid_o)
   );

   int checks = 0, errors = 0;
   bit done = 0;
   logic [47:0] rxq[$];
   logic [47:0] sentq[NSRC][$];
   logic [23:0] fl[NSRC], fr[NSRC];
   int mode_b = 0, wl_b = 16;

   always @(negedge clk) if (rst_n && valid_o) rxq.push_back({left_o, right_o});

   task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] sext(logic [23:0] w, int wl);
      logic [23:0] r = w;
      for (int i = wl; i < 24; i++) r[i] = w[wl-1];
      return r;
   endfunction

   function automatic logic [1:0] enc(int mode, int wl, int b, logic [23:0] l, logic [23:0] r);
      int h = b / SLOT;
      int i = b % SLOT;
      logic [23:0] w = (h != 0) ? r : l;
      logic f, d;
      d = 1'b0;
      case (mode)
         0: begin f = (h == 0); if (i < wl) d = w[wl-1-i]; end
         1: begin f = (h != 0); if (i >= 1 && i <= wl) d = w[wl-i]; end
         2: begin f = (h == 0); if (i >= SLOT - wl) d = w[SLOT-1-i]; end
         default: begin
            f = (b == 0);
            if (b < wl) d = l[wl-1-b];
            else if (b < 2 * wl) d = r[2*wl-1-b];
         end
      endcase
      return {f, d};
   endfunction

   function automatic bit in_rx(logic [47:0] v);
      foreach (rxq[k]) if (rxq[k] == v) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [23:0] rnd(int wl);
      return 24'($urandom) & ((24'd1 << wl) - 24'd1);
   endfunction

   task automatic new_words();
      for (int g = 0; g < NSRC; g++) begin
         fl[g] = rnd(wl_b);
         fr[g] = rnd(wl_b);
      end
   endtask

   task automatic send_frame(int sw_bit, logic [1:0] new_sel);
      for (int g = 0; g < NSRC; g++)
         sentq[g].push_back({sext(fl[g], wl_b), sext(fr[g], wl_b)});
      for (int b = 0; b < 2 * SLOT; b++) begin
         repeat (HALF_BIT) @(posedge clk);
         #1;
         sbck = '0;
         if (b == sw_bit) sel = new_sel;
         for (int g = 0; g < NSRC; g++) {sfrm[g], sdat[g]} = enc(mode_b, wl_b, b, fl[g], fr[g]);
         repeat (HALF_BIT) @(posedge clk);
         #1;
         sbck = '1;
      end
   endtask

   task automatic frames(int n);
      for (int k = 0; k < n; k++) begin
         new_words();
         send_frame(-1, 2'd0);
      end
   endtask

   task automatic clear_all();
      rxq.delete();
      for (int g = 0; g < NSRC; g++) sentq[g].delete();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (5) @(posedge clk);
      #1;
      // R11 reset state, R10 forwarding low while disabled
      check(valid_o == 1'b0, "R11 valid in reset", 48'(valid_o), 48'd0);
      check(left_o == 24'd0 && right_o == 24'd0, "R11 samples in reset", {left_o, right_o}, 48'd0);
      check({fwd_data, fwd_frm, fwd_bit} == 3'b000, "R10 forward off", 48'({fwd_data, fwd_frm, fwd_bit}), 48'd0);
      rst_n = 1'b1;

      // R1..R6: every framing with every word length, group 0 (R11 default select)
      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c < 3; c++) begin
            string tag;
            int idx;
            tag = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
            fmt = {2'(c), 2'(m)};
            mode_b = m;
            wl_b = 16 + 4 * c;
            frames(2);
            clear_all();
            // directed extremes for R6: largest positive left, most negative right
            for (int g = 0; g < NSRC; g++) begin
               fl[g] = (24'd1 << (wl_b - 1)) - 24'd1;
               fr[g] = 24'd1 << (wl_b - 1);
            end
            send_frame(-1, 2'd0);
            frames(4);
            repeat (20) @(posedge clk);
            idx = -1;
            foreach (rxq[k]) if (idx < 0 && rxq[k] == sentq[0][0]) idx = k;
            check(idx >= 0, $sformatf("%s/R1/R6 fmt=%h first frame", tag, fmt),
                  (rxq.size() > 0) ? rxq[0] : 48'd0, sentq[0][0]);
            if (idx >= 0) begin
               for (int k = 1; k < 4; k++) begin
                  logic [47:0] got;
                  got = (idx + k < rxq.size()) ? rxq[idx+k] : 48'd0;
                  check(got == sentq[0][k], $sformatf("%s/R6/R7 fmt=%h frame %0d", tag, fmt, k), got, sentq[0][k]);
               end
            end
         end
      end

      // R9: switch group 0 -> 1 in the middle of a frame, frame-aligned 24-bit
      fmt = 4'b1000;
      mode_b = 0;
      wl_b = 24;
      sel = 2'd0;
      frames(2);
      clear_all();
      new_words();
      send_frame(-1, 2'd0);
      new_words();
      send_frame(20, 2'd1);
      frames(3);
      repeat (20) @(posedge clk);
      check(in_rx(sentq[0][1]), "R9 last frame of old group", 48'd0, sentq[0][1]);
      check(!in_rx(sentq[1][1]), "R9 cut frame of new group", sentq[1][1], 48'd0);
      check(in_rx(sentq[1][3]), "R8/R9 new group frame 3", 48'd0, sentq[1][3]);
      check(in_rx(sentq[1][4]), "R8/R9 new group frame 4", 48'd0, sentq[1][4]);
      foreach (rxq[k]) begin
         bit hit = 1'b0;
         for (int j = 0; j < sentq[0].size(); j++)
            if (rxq[k] == sentq[0][j] || rxq[k] == sentq[1][j]) hit = 1'b1;
         check(hit, "R9 no mixed sample", rxq[k], 48'd0);
      end

      // R8: reserved value keeps group 1, then group 2
      sel = 2'd3;
      clear_all();
      frames(3);
      repeat (20) @(posedge clk);
      check(in_rx(sentq[1][2]), "R8 reserved keeps group", 48'd0, sentq[1][2]);
      check(!in_rx(sentq[2][2]), "R8 reserved not group 2", sentq[2][2], 48'd0);
      sel = 2'd2;
      clear_all();
      frames(3);
      repeat (20) @(posedge clk);
      check(in_rx(sentq[2][2]), "R8 group 2 selected", 48'd0, sentq[2][2]);

      // R10: forwarding of the raw signals of group 2
      fwd_en = 1'b1;
      sdat = 3'b100; sfrm = 3'b001; sbck = 3'b110;
      #1;
      check({fwd_data, fwd_frm, fwd_bit} == 3'b101, "R10 forward pattern 1", 48'({fwd_data, fwd_frm, fwd_bit}), 48'b101);
      sdat = 3'b011; sfrm = 3'b110; sbck = 3'b001;
      #1;
      check({fwd_data, fwd_frm, fwd_bit} == 3'b010, "R10 forward pattern 2", 48'({fwd_data, fwd_frm, fwd_bit}), 48'b010);
      fwd_en = 1'b0;
      sdat = 3'b111; sfrm = 3'b111; sbck = 3'b111;
      #1;
      check({fwd_data, fwd_frm, fwd_bit} == 3'b000, "R10 forward disabled", 48'({fwd_data, fwd_frm, fwd_bit}), 48'd0);

      repeat (10) @(posedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule